// File: doc/BRIEF.md
# Receive Character Queue with Fill Alarm

This block buffers received characters between a line scanner, which pushes one 16-bit entry per write strobe, and a host register interface. The host sees the oldest entry on a head register. A read strobe on that register consumes the entry, so the next oldest entry moves up to the head on the following cycle. The queue holds 64 entries by default.

A status word holds two bytes. The upper byte is the current fill level, which the host can read at any time. The lower byte is a host-writable alarm level. A receive interrupt request is raised while the fill level is above the alarm level and the receive enable is set. An overflow interrupt request latches when the scanner tries to push into a full queue while the overflow enable is set. It holds until the host acknowledges it.

Top module: `rx_alarm_fifo`

## Requirements
- R1: Entries leave the queue in the order in which they were accepted, up to 64 stored entries of 16 bits each.
- R2: While the queue holds at least one entry, `head_q[16]` is 1 and `head_q[15:0]` is the oldest entry. A cycle with `rd_en` high removes that entry, and the next entry is on `head_q` after that clock edge.
- R3: `status_q[15:8]` equals the number of stored entries. It changes by at most one per cycle and never exceeds 64.
- R4: While the queue is empty, `head_q` is all zeros, including the valid bit 16. A read strobe then leaves the fill level at zero.
- R5: A write and a read in the same cycle on a queue that is neither empty nor full leave the fill level unchanged and keep the order. On an empty queue the write is stored and the read does nothing.
- R6: A write while the queue is full is rejected, and the stored entries are unchanged. A read in the same cycle still removes the head, so the fill level drops by one.
- R7: A cycle with `lvl_we` high loads `lvl_wdata` into the alarm level, which is visible on `status_q[7:0]` after that edge.
- R8: `rx_irq` is high exactly when `rx_ie` is high and the fill level is strictly greater than the alarm level. An equal fill level and alarm level give no request.
- R9: A rejected write while `ovf_ie` is high sets `ovf_irq` from the next cycle. `ovf_irq` stays high until a cycle with `ovf_ack` high. When both happen in the same cycle, the set wins.
- R10: Reset clears the fill level, the alarm level and `ovf_irq`, so `rx_irq` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Scanner push strobe |
| wr_data | input | 16 | Entry to push |
| rd_en | input | 1 | Host read strobe on the head register (consumes the head) |
| head_q | output | 17 | Bit 16 is valid, bits 15:0 are the oldest entry |
| lvl_we | input | 1 | Alarm level write strobe |
| lvl_wdata | input | 8 | New alarm level |
| status_q | output | 16 | Fill level in 15:8, alarm level in 7:0 |
| rx_ie | input | 1 | Receive interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ovf_ack | input | 1 | Clears the overflow request |
| rx_irq | output | 1 | Receive interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The assertions check, on every cycle, the properties that depend only on the status and head ports:
- the fill level stays within bounds and moves by at most one per cycle;
- the valid bit tracks a non-empty queue;
- a full queue rejects a push;
- the alarm register loads on its strobe;
- the overflow request latches and holds.

Data ordering, and the rule that a rejected entry never appears later at the head, can only be shown by the bench scenarios. The bench compares every popped entry against its own queue model. It also runs directed sequences for an exact fill-to-alarm boundary and for a reset in the middle of a run.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [1:0] {
      RXQ_IDLE = 2'b00,
      RXQ_PUSH = 2'b01,
      RXQ_POP  = 2'b10,
      RXQ_BOTH = 2'b11
   } rxq_op_e;

   function automatic rxq_op_e rxq_decode(input logic push, input logic pop);
      return rxq_op_e'({pop, push});
   endfunction

   function automatic bit rxq_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned PTR_W = $clog2(DEPTH),
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   output logic             push,
   output logic             full,
   output logic             empty,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);

   logic    pop;
   rxq_op_e op;
   logic [PTR_W-1:0] wr_ptr_inc;
   logic [PTR_W-1:0] rd_ptr_inc;

   assign full  = (count == CNT_MAX);
   assign empty = (count == '0);
   assign push  = wr_en && !full;
   assign pop   = rd_en && !empty;
   assign op    = rxq_decode(push, pop);

   generate
      if (rxq_is_pow2(DEPTH)) begin : g_wrap_natural
         assign wr_ptr_inc = wr_ptr + 1'b1;
         assign rd_ptr_inc = rd_ptr + 1'b1;
      end else begin : g_wrap_compare
         assign wr_ptr_inc = (wr_ptr == PTR_TOP) ? '0 : wr_ptr + 1'b1;
         assign rd_ptr_inc = (rd_ptr == PTR_TOP) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr_inc;
         if (pop)  rd_ptr <= rd_ptr_inc;
         unique case (op)
            RXQ_PUSH: count <= count + 1'b1;
            RXQ_POP:  count <= count - 1'b1;
            default:  count <= count;
         endcase
      end
   end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_ptr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wr_ptr] <= wr_data;
   end

   assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
   parameter int unsigned LVL_W = 8,
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic             lvl_we,
   input  logic [LVL_W-1:0] lvl_wdata,
   input  logic             rx_ie,
   input  logic             ovf_ie,
   input  logic             ovf_hit,
   input  logic             ovf_ack,
   output logic [LVL_W-1:0] alarm,
   output logic             rx_irq,
   output logic             ovf_irq
);

   logic [LVL_W-1:0] fill_ext;

   assign fill_ext = LVL_W'(count);
   assign rx_irq   = rx_ie && (fill_ext > alarm);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm   <= '0;
         ovf_irq <= 1'b0;
      end else begin
         if (lvl_we) alarm <= lvl_wdata;
         if (ovf_hit && ovf_ie) ovf_irq <= 1'b1;
         else if (ovf_ack)      ovf_irq <= 1'b0;
      end
   end

endmodule

// File: rtl/rx_alarm_fifo.sv
module rx_alarm_fifo
   import rxq_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned LVL_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 rd_en,
   output logic [DATA_W:0]      head_q,
   input  logic                 lvl_we,
   input  logic [LVL_W-1:0]     lvl_wdata,
   output logic [2*LVL_W-1:0]   status_q,
   input  logic                 rx_ie,
   input  logic                 ovf_ie,
   input  logic                 ovf_ack,
   output logic                 rx_irq,
   output logic                 ovf_irq
);

   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_alarm_fifo: DEPTH must be at least 2");
      end
      if (CNT_W > LVL_W) begin : g_bad_level
         $error("rx_alarm_fifo: fill level does not fit the status byte");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_alarm_fifo: DATA_W must be positive");
      end
   endgenerate

   logic             push;
   logic             full;
   logic             empty;
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [CNT_W-1:0] count;
   logic [DATA_W-1:0] rd_data;
   logic [LVL_W-1:0] alarm;

   rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .push   (push),
      .full   (full),
      .empty  (empty),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .count  (count)
   );

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
      .clk     (clk),
      .we      (push),
      .wr_ptr  (wr_ptr),
      .wr_data (wr_data),
      .rd_ptr  (rd_ptr),
      .rd_data (rd_data)
   );

   rxq_irq #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .count     (count),
      .lvl_we    (lvl_we),
      .lvl_wdata (lvl_wdata),
      .rx_ie     (rx_ie),
      .ovf_ie    (ovf_ie),
      .ovf_hit   (wr_en && full),
      .ovf_ack   (ovf_ack),
      .alarm     (alarm),
      .rx_irq    (rx_irq),
      .ovf_irq   (ovf_irq)
   );

   assign head_q   = empty ? '0 : {1'b1, rd_data};
   assign status_q = {LVL_W'(count), alarm};

endmodule

// File: rtl/rx_alarm_fifo_chk.sv
module rx_alarm_fifo_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned LVL_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               rd_en,
   input logic [DATA_W:0]    head_q,
   input logic               lvl_we,
   input logic [LVL_W-1:0]   lvl_wdata,
   input logic [2*LVL_W-1:0] status_q,
   input logic               rx_ie,
   input logic               ovf_ie,
   input logic               ovf_ack,
   input logic               rx_irq,
   input logic               ovf_irq
);

   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

   logic [LVL_W-1:0] fill;
   logic [LVL_W-1:0] alarm;

   assign fill  = status_q[2*LVL_W-1:LVL_W];
   assign alarm = status_q[LVL_W-1:0];

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL_LVL); // R3
   AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fill == $past(fill) || fill == $past(fill) + 1'b1 || fill == $past(fill) - 1'b1)); // R3
   AST_HEAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (fill != '0) |-> head_q[DATA_W]); // R2
   AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == '0) |-> (head_q == '0)); // R4
   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && fill == '0) |=> (fill == '0)); // R4
   AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && fill != '0 && fill != FULL_LVL) |=> $stable(fill)); // R5
   AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && fill == FULL_LVL) |=> (fill == FULL_LVL)); // R6
   AST_ALARM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_we |=> (alarm == $past(lvl_wdata))); // R7
   AST_RX_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (rx_ie && fill > alarm)); // R8
   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ovf_ie && fill == FULL_LVL) |=> ovf_irq); // R9
   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_irq && !ovf_ack) |=> ovf_irq); // R9

endmodule

bind rx_alarm_fifo rx_alarm_fifo_chk #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .head_q    (head_q),
   .lvl_we    (lvl_we),
   .lvl_wdata (lvl_wdata),
   .status_q  (status_q),
   .rx_ie     (rx_ie),
   .ovf_ie    (ovf_ie),
   .ovf_ack   (ovf_ack),
   .rx_irq    (rx_irq),
   .ovf_irq   (ovf_irq)
);

// File: tb/rx_alarm_fifo_bench.sv
module rx_alarm_fifo_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [16:0] head_q;
   logic        lvl_we = 1'b0;
   logic [7:0]  lvl_wdata = '0;
   logic [15:0] status_q;
   logic        rx_ie = 1'b0;
   logic        ovf_ie = 1'b0;
   logic        ovf_ack = 1'b0;
   logic        rx_irq;
   logic        ovf_irq;

   int tests = 0;
   int fails = 0;

   logic [15:0] q [$];
   logic [7:0]  m_alarm = '0;
   logic        m_ovf = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_alarm_fifo u_rx_alarm_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .head_q(head_q), .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .status_q(status_q),
      .rx_ie(rx_ie), .ovf_ie(ovf_ie), .ovf_ack(ovf_ack), .rx_irq(rx_irq), .ovf_irq(ovf_irq)
   );

   function automatic logic [16:0] exp_head();
      return (q.size() > 0) ? {1'b1, q[0]} : 17'h0;
   endfunction

   function automatic logic [15:0] exp_status();
      return {8'(q.size()), m_alarm};
   endfunction

   function automatic logic exp_rx_irq();
      return rx_ie && (q.size() > int'(m_alarm));
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R2 head", 32'(head_q), 32'(exp_head()));
      chk("R3 fill", 32'(status_q[15:8]), 32'(q.size()));
      chk("R7 alarm", 32'(status_q[7:0]), 32'(m_alarm));
      chk("R8 rx_irq", 32'(rx_irq), 32'(exp_rx_irq()));
      chk("R9 ovf_irq", 32'(ovf_irq), 32'(m_ovf));
   endtask

   task automatic model_edge(input bit w, input logic [15:0] d, input bit r,
                             input bit lw, input logic [7:0] ld, input bit ack);
      bit was_full;
      bit was_empty;
      was_full  = (q.size() == DEPTH);
      was_empty = (q.size() == 0);
      if (r && !was_empty) void'(q.pop_front());
      if (w && !was_full) q.push_back(d);
      if (lw) m_alarm = ld;
      if (w && was_full && ovf_ie) m_ovf = 1'b1;
      else if (ack) m_ovf = 1'b0;
   endtask

   task automatic cyc(input bit w, input logic [15:0] d, input bit r,
                      input bit lw, input logic [7:0] ld, input bit ack);
      wr_en = w; wr_data = d; rd_en = r; lvl_we = lw; lvl_wdata = ld; ovf_ack = ack;
      @(posedge clk);
      model_edge(w, d, r, lw, ld, ack);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; lvl_we = 1'b0; ovf_ack = 1'b0;
      compare_all();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0; rd_en = 1'b0; lvl_we = 1'b0; ovf_ack = 1'b0;
      repeat (2) @(posedge clk);
      q.delete();
      m_alarm = '0;
      m_ovf = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R10 fill", 32'(status_q[15:8]), 32'h0);
      chk("R10 alarm", 32'(status_q[7:0]), 32'h0);
      chk("R10 ovf", 32'(ovf_irq), 32'h0);
      chk("R10 rx_irq", 32'(rx_irq), 32'h0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h1A2B3C));
      rx_ie = 1'b1;
      @(negedge clk);
      do_reset();

      // R4: read on an empty queue
      cyc(0, 16'h0, 1, 0, 8'h0, 0);
      chk("R4 empty head", 32'(head_q), 32'h0);
      chk("R4 empty fill", 32'(status_q[15:8]), 32'h0);

      // R5: write and read together on an empty queue
      cyc(1, 16'hA5A5, 1, 0, 8'h0, 0);
      chk("R5 empty both fill", 32'(status_q[15:8]), 32'h1);
      chk("R5 empty both head", 32'(head_q), 32'h1A5A5);
      cyc(1, 16'h1234, 0, 0, 8'h0, 0);
      cyc(1, 16'h5678, 1, 0, 8'h0, 0);
      chk("R5 mid both fill", 32'(status_q[15:8]), 32'h2);
      chk("R5 mid both head", 32'(head_q), 32'h11234);
      cyc(0, 16'h0, 1, 0, 8'h0, 0);
      cyc(0, 16'h0, 1, 0, 8'h0, 0);

      // R8: fill level equal to and above the alarm level
      cyc(0, 16'h0, 0, 1, 8'd5, 0);
      for (int i = 0; i < 5; i++) cyc(1, 16'(16'h100 + i), 0, 0, 8'h0, 0);
      chk("R8 equal no irq", 32'(rx_irq), 32'h0);
      cyc(1, 16'h105, 0, 0, 8'h0, 0);
      chk("R8 above irq", 32'(rx_irq), 32'h1);
      rx_ie = 1'b0;
      #1 chk("R8 disabled", 32'(rx_irq), 32'h0);
      rx_ie = 1'b1;

      // R6 / R9: fill up, then push while full, with the enable off and then on
      while (q.size() < DEPTH) cyc(1, 16'(16'h2000 + q.size()), 0, 0, 8'h0, 0);
      ovf_ie = 1'b0;
      cyc(1, 16'hDEAD, 0, 0, 8'h0, 0);
      chk("R9 disabled", 32'(ovf_irq), 32'h0);
      chk("R6 full fill", 32'(status_q[15:8]), 32'(DEPTH));
      ovf_ie = 1'b1;
      cyc(1, 16'hBEEF, 0, 0, 8'h0, 0);
      chk("R9 set", 32'(ovf_irq), 32'h1);
      cyc(0, 16'h0, 0, 0, 8'h0, 0);
      chk("R9 hold", 32'(ovf_irq), 32'h1);
      cyc(1, 16'hCAFE, 1, 0, 8'h0, 1);
      chk("R9 set beats ack", 32'(ovf_irq), 32'h1);
      chk("R6 full with read", 32'(status_q[15:8]), 32'(DEPTH - 1));
      cyc(0, 16'h0, 0, 0, 8'h0, 1);
      chk("R9 ack", 32'(ovf_irq), 32'h0);

      // R1: drain and compare the order
      while (q.size() > 0) begin
         chk("R1 order", 32'(head_q), 32'(exp_head()));
         cyc(0, 16'h0, 1, 0, 8'h0, 0);
      end

      // Random traffic, in phases that favour filling and then draining
      for (int ph = 0; ph < 12; ph++) begin
         for (int k = 0; k < 250; k++) begin
            bit w;
            bit r;
            bit lw;
            w  = ($urandom_range(0, 99) < ((ph % 2 == 0) ? 75 : 30));
            r  = ($urandom_range(0, 99) < ((ph % 2 == 0) ? 30 : 75));
            lw = ($urandom_range(0, 99) < 3);
            ovf_ie = ($urandom_range(0, 3) != 0);
            rx_ie  = ($urandom_range(0, 7) != 0);
            cyc(w, 16'($urandom()), r, lw, 8'($urandom_range(0, 70)),
                ($urandom_range(0, 19) == 0));
         end
      end

      // R10: reset in the middle of a run
      for (int i = 0; i < 10; i++) cyc(1, 16'(i), 0, (i == 0), 8'd2, 0);
      do_reset();

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule